// File: doc/BRIEF.md
# Display FIFO DMA Request Generator

This block keeps a video display FIFO supplied with data by issuing DMA request strobes. It compares the FIFO fill level with a programmable threshold. Whenever the level is below the threshold, the FIFO has room for another block transfer, so the block issues a one-cycle request. At most one request is outstanding at a time. A new request waits for an acknowledge from the DMA side, which signals that the previous transfer has landed.

A per-field budget caps the number of requests. A field-start strobe loads a down-counter with the event count for the field being started. One count is provided for the first field and one for the second. Each request takes one from the budget. At zero, requests stop until the next field start. Software can then retarget the DMA while the FIFO keeps draining to the display. A status output shows when the budget is spent.

Top module: `dfifo_dma_req_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_o is 0 and exhausted_o is 1, because the budget counter resets to zero.
- R2: A cycle with field_start_i high loads the budget counter at that clock edge. It loads cnt_f1_i when field_id_i is 0 and cnt_f2_i when field_id_i is 1.
- R3: req_o pulses high for exactly one cycle, in the cycle after a cycle in which all of the following hold: en_i is 1, level_i < thresh_i, the budget is nonzero, no request is outstanding, and field_start_i is 0.
- R4: No request is issued from a cycle in which level_i is greater than or equal to thresh_i.
- R5: After a request, no further request is issued until ack_i has been seen high on a clock edge. The earliest next request comes in the cycle after the cycle following that acknowledge.
- R6: Each issued request decrements the budget by one. Once it reaches zero, no request is issued until the next field start.
- R7: A field count of zero issues no requests in that field, and exhausted_o stays 1.
- R8: When field_start_i arrives in a cycle that would otherwise issue a request, the reload wins. No request is issued from that cycle, and any outstanding request is cleared.
- R9: While en_i is 0, no request is issued and the budget counter holds its value.
- R10: exhausted_o is 1 exactly when the budget counter is zero. It clears in the cycle after a reload with a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Request generation enable |
| level_i | input | LVL_W | Current FIFO fill level |
| thresh_i | input | LVL_W | Request threshold |
| cnt_f1_i | input | CNT_W | Request budget for field 1 |
| cnt_f2_i | input | CNT_W | Request budget for field 2 |
| field_start_i | input | 1 | Field start strobe |
| field_id_i | input | 1 | Field being started (0 = field 1, 1 = field 2) |
| ack_i | input | 1 | Outstanding transfer has landed |
| req_o | output | 1 | One-cycle DMA request strobe |
| exhausted_o | output | 1 | Budget counter is zero |

## Verification
The bench builds the block with LVL_W = 5 and CNT_W = 4. With these widths, the largest budget of 15 is spent within a few dozen cycles, and a random level and threshold fall on each side of the comparison boundary, including equality, with good odds. Directed runs spend whole budgets for both fields, with and without acknowledges. A random run then collides field starts with requests, acknowledges and enable toggles, and a reference model tracks every cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic {
    FIELD_ONE = 1'b0,
    FIELD_TWO = 1'b1
  } field_e;
endpackage

// File: rtl/dreq_lvl_cmp.sv
module dreq_lvl_cmp #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             room_o
);
  // room for another block whenever level sits strictly below threshold
  assign room_o = (level_i < thresh_i);
endmodule

// File: rtl/dreq_evt_cnt.sv
module dreq_evt_cnt
  import dreq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  field_e           field_i,
  input  logic [CNT_W-1:0] cnt_f1_i,
  input  logic [CNT_W-1:0] cnt_f2_i,
  input  logic             dec_i,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  assign load_val = (field_i == FIELD_TWO) ? cnt_f2_i : cnt_f1_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                         cnt_d = load_val;
    else if (dec_i && (cnt_q != '0))    cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dreq_issue.sv
module dreq_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic room_i,
  input  logic avail_i,
  input  logic reload_i,
  input  logic ack_i,
  output logic fire_o,
  output logic req_o
);
  logic pend_q, pend_d, req_q;

  // reload wins over a same-cycle request
  assign fire_o = en_i && room_i && avail_i && !pend_q && !reload_i;

  always_comb begin
    pend_d = pend_q;
    if (reload_i)    pend_d = 1'b0;
    else if (fire_o) pend_d = 1'b1;
    else if (ack_i)  pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= fire_o;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dfifo_dma_req_gen.sv
module dfifo_dma_req_gen
  import dreq_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] cnt_f1_i,
  input  logic [CNT_W-1:0] cnt_f2_i,
  input  logic             field_start_i,
  input  logic             field_id_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             exhausted_o
);
  logic   room, zero, fire;
  field_e fld;

  assign fld = field_e'(field_id_i);

  dreq_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i  (level_i),
    .thresh_i (thresh_i),
    .room_o   (room)
  );

  dreq_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (field_start_i),
    .field_i  (fld),
    .cnt_f1_i (cnt_f1_i),
    .cnt_f2_i (cnt_f2_i),
    .dec_i    (fire),
    .zero_o   (zero)
  );

  dreq_issue u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .room_i   (room),
    .avail_i  (!zero),
    .reload_i (field_start_i),
    .ack_i    (ack_i),
    .fire_o   (fire),
    .req_o    (req_o)
  );

  assign exhausted_o = zero;
endmodule

// File: rtl/dfifo_dma_req_gen_chk.sv
module dfifo_dma_req_gen_chk #(
  parameter int LVL_W = 8,
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [LVL_W-1:0] level_i,
  input logic [LVL_W-1:0] thresh_i,
  input logic [CNT_W-1:0] cnt_f1_i,
  input logic [CNT_W-1:0] cnt_f2_i,
  input logic             field_start_i,
  input logic             field_id_i,
  input logic             ack_i,
  input logic             req_o,
  input logic             exhausted_o
);
  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = field_id_i ? cnt_f2_i : cnt_f1_i;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  a_r4_no_req_without_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(level_i < thresh_i) |=> !req_o);

  a_r6_no_req_when_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exhausted_o && !field_start_i) |=> !req_o);

  a_r8_reload_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> !req_o);

  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o);

  a_r10_reload_clears_exh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && (sel_cnt != '0)) |=> !exhausted_o);

  a_r7_zero_load_exh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && (sel_cnt == '0)) |=> exhausted_o);
endmodule

bind dfifo_dma_req_gen dfifo_dma_req_gen_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dfifo_dma_req_gen_bench.sv
module dfifo_dma_req_gen_bench;
  localparam int LVL_W = 5;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fs = 1'b0, fid = 1'b0, ack_man = 1'b0, ack_auto_q = 1'b0, auto_ack = 1'b0;
  logic [LVL_W-1:0] level = '0, thresh = '0;
  logic [CNT_W-1:0] c1 = '0, c2 = '0;
  logic ack, req, exh;

  assign ack = ack_auto_q | ack_man;

  always #4 clk = ~clk; // 125 MHz

  dfifo_dma_req_gen #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_dfifo_dma_req_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .level_i(level), .thresh_i(thresh),
    .cnt_f1_i(c1), .cnt_f2_i(c2), .field_start_i(fs), .field_id_i(fid),
    .ack_i(ack), .req_o(req), .exhausted_o(exh)
  );

  int checks = 0, errors = 0, n_req = 0;
  bit run_cmp = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_cnt = 0;
  bit  m_pend = 0, m_req = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_req = 0;
    end else begin
      bit elig;
      elig = en && (int'(level) < int'(thresh)) && (m_cnt > 0) && !m_pend && !fs;
      m_req = elig;
      if (fs) begin
        m_cnt  = fid ? int'(c2) : int'(c1);
        m_pend = 0;
      end else if (elig) begin
        m_cnt--; m_pend = 1;
      end else if (ack) begin
        m_pend = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(req == m_req, "R3 req_o vs model", int'(req), int'(m_req));
      chk(exh == (m_cnt == 0), "R10 exhausted_o vs model", int'(exh), int'(m_cnt == 0));
    end
    if (req) n_req++;
    ack_auto_q <= auto_ack && req;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_field(input bit id);
    fid = id; fs = 1'b1;
    step(1);
    fs = 1'b0;
  endtask

  function automatic int since(input int b);
    return n_req - b;
  endfunction

  int base;

  initial begin
    step(2);
    chk(req == 1'b0, "R1 req in reset", int'(req), 0);
    chk(exh == 1'b1, "R1 exhausted in reset", int'(exh), 1);
    rst_n = 1'b1;
    step(1);
    chk(exh == 1'b1, "R1 exhausted after reset", int'(exh), 1);
    run_cmp = 1'b1;

    // no budget loaded yet: nothing issued
    level = 5'd2; thresh = 5'd8; en = 1'b1; auto_ack = 1'b1;
    @(posedge clk); base = n_req; step(8); @(posedge clk);
    chk(since(base) == 0, "R7 no budget before field start", since(base), 0);

    // R2 / R6: field 1 budget
    c1 = 4'd3; c2 = 4'd5;
    @(negedge clk);
    @(posedge clk); base = n_req; @(negedge clk);
    start_field(1'b0);
    chk(exh == 1'b0, "R2 field1 load", int'(exh), 0);
    step(20); @(posedge clk);
    chk(since(base) == 3, "R6 field1 request count", since(base), 3);
    chk(exh == 1'b1, "R6 exhausted after budget", int'(exh), 1);

    // R2 / R6: field 2 budget
    @(negedge clk); @(posedge clk); base = n_req; @(negedge clk);
    start_field(1'b1);
    step(30); @(posedge clk);
    chk(since(base) == 5, "R2 field2 request count", since(base), 5);

    // R5: one outstanding without acknowledge
    @(negedge clk); auto_ack = 1'b0;
    @(posedge clk); base = n_req; @(negedge clk);
    start_field(1'b0);
    step(10); @(posedge clk);
    chk(since(base) == 1, "R5 held without ack", since(base), 1);
    @(negedge clk); ack_man = 1'b1; step(1); ack_man = 1'b0;
    step(10); @(posedge clk);
    chk(since(base) == 2, "R5 released by ack", since(base), 2);

    // R4: level equal to threshold, then just below
    @(negedge clk); auto_ack = 1'b1; level = 5'd8;
    @(posedge clk); base = n_req; @(negedge clk);
    start_field(1'b0);
    step(10); @(posedge clk);
    chk(since(base) == 0, "R4 level at threshold", since(base), 0);
    @(negedge clk); level = 5'd7;
    step(12); @(posedge clk);
    chk(since(base) == 3, "R3 level below threshold", since(base), 3);

    // R7: zero budget
    @(negedge clk); c1 = 4'd0;
    @(posedge clk); base = n_req; @(negedge clk);
    start_field(1'b0);
    chk(exh == 1'b1, "R7 zero count exhausted", int'(exh), 1);
    step(10); @(posedge clk);
    chk(since(base) == 0, "R7 zero count no requests", since(base), 0);

    // R8: field start collides with an eligible cycle
    @(negedge clk); auto_ack = 1'b0; en = 1'b0; c1 = 4'd4;
    start_field(1'b0);
    step(2);
    en = 1'b1; fs = 1'b1; fid = 1'b0;
    step(1); fs = 1'b0;
    chk(req == 1'b0, "R8 request dropped on reload", int'(req), 0);
    step(1);
    chk(req == 1'b1, "R3 request after reload", int'(req), 1);
    step(1);
    chk(req == 1'b0, "R3 single-cycle pulse", int'(req), 0);

    // R9: disabled holds counter
    en = 1'b0; ack_man = 1'b1; step(1); ack_man = 1'b0; auto_ack = 1'b1;
    @(posedge clk); base = n_req; step(10); @(posedge clk);
    chk(since(base) == 0, "R9 no requests while disabled", since(base), 0);
    chk(exh == 1'b0, "R9 budget held while disabled", int'(exh), 0);
    @(negedge clk); en = 1'b1;
    step(12); @(posedge clk);
    chk(since(base) == 3, "R9 held budget spent after enable", since(base), 3);

    // random stress against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      level    = LVL_W'($urandom_range(0, 31));
      thresh   = LVL_W'($urandom_range(0, 31));
      c1       = CNT_W'($urandom_range(0, 15));
      c2       = CNT_W'($urandom_range(0, 15));
      fs       = ($urandom_range(0, 19) == 0);
      fid      = 1'($urandom_range(0, 1));
      en       = ($urandom_range(0, 7) != 0);
      ack_man  = ($urandom_range(0, 5) == 0);
      auto_ack = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk); fs = 1'b0; ack_man = 1'b0;
    step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule